// File: doc/BRIEF.md
# Open-Drain Two-Pin Parallel Port

This block owns a small group of general-purpose pads, two by default, that are driven open-drain beside a serial codec link. Each pad has an output latch. A latched 0 turns on the pull-down. A latched 1 turns it off, so an external pull-up or another device sets the level. To use a pad as an input, software leaves its latch at 1 and reads the level back. Pad levels pass through a two-stage synchronizer before the block samples them.

The port behaves differently in each link mode. In control mode it is read-only. The frame formatter pulses a strobe on the bit-clock edge it picks, and the pad levels are captured into a control status value that goes out in that same frame. In data mode new latch values come in on a valid/ready write stream. A written value is held pending and applied a fixed number of master-clock cycles after the frame-sync rising edge. Pad levels are sampled at a second fixed offset and shown to the formatter one frame later.

The write stream has simple back-pressure. `wr_ready` is high in data mode and low in control mode. A beat transfers on any clock edge where `wr_valid` and `wr_ready` are both high. A sender that sees `wr_ready` low keeps its data; nothing is queued on its behalf.

Top module: `pio_port`

## Requirements
- R1: During and after reset, every latch holds 1, so `pin_oe` is all 0. `ctl_status` and `data_rd` are all 1, and no write is pending.
- R2: `pin_oe[i]` is 1 (pad pulled low) exactly when latch bit i is 0. A latch bit of 1 releases the pad.
- R3: In control mode (`mode_data`=0), `wr_ready` is 0 and `wr_valid` is ignored. `pin_oe` does not change, and frame-sync edges do not alter `data_rd`.
- R4: In control mode, `ctl_status` takes the synchronized pad levels on the clock edge where `ctl_smp_stb` is 1, visible from the next cycle, and holds at all other edges. A pad change reaches the sampler only after two clock edges.
- R5: In data mode, frame edge 0 is the clock edge at which `fsync` is first seen high after being seen low. An accepted write reaches the latch at edge WR_DLY (default 11) and not earlier.
- R6: When several writes are accepted before the next update point, only the last one is applied.
- R7: In data mode, the synchronized pad levels are sampled at frame edge RD_DLY (default 8). That sample appears on `data_rd` from edge 0 of the following frame and holds for the whole frame.
- R8: In data mode, `ctl_smp_stb` is ignored and `ctl_status` keeps its value.
- R9: Entering control mode discards a pending write, so it is never applied.
- R10: An update point with no pending write leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_data | input | 1 | 1 = data mode, 0 = control mode |
| fsync | input | 1 | Frame sync level, synchronous to clk |
| ctl_smp_stb | input | 1 | Control-mode capture strobe from the formatter (qualified bit-clock edge) |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat accepted when high together with wr_valid |
| wr_data | input | N_PIN | Latch value; bit i drives pad i |
| pin_in | input | N_PIN | Level seen on each pad |
| pin_oe | output | N_PIN | Pull-down enable per pad |
| ctl_status | output | N_PIN | Pad levels captured in control mode |
| data_rd | output | N_PIN | Pad levels sampled in the previous data-mode frame |

## Verification
- A written value appears on `pin_oe` after frame edge WR_DLY. The bench checks the old value after edge WR_DLY-1 and the new value after edge WR_DLY.
- A data-mode sample taken at edge RD_DLY is checked just after edge 0 of the following frame. In that frame the latch change comes after the sample, so the bench expects the external level ANDed with the latch of the previous frame.
- The control-mode capture is checked one cycle after the strobe. One strobe is placed in the same cycle as a pad change, and the bench expects the old level there because of the two-stage synchronizer.
- Every check is sampled on the falling clock edge, half a cycle after the rising edge that produces the result.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

  typedef enum logic {
    MODE_CTL  = 1'b0,
    MODE_DATA = 1'b1
  } pio_mode_e;

  // bits needed to hold values 0..max_val
  function automatic int unsigned ctr_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
module pio_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  // released pads read as 1, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_frame_timer.sv
`timescale 1ns/1ps
module pio_frame_timer #(
  parameter int WR_DLY = 11,
  parameter int RD_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fsync,
  output logic fs_rise,
  output logic wr_tick,
  output logic rd_tick
);
  import pio_pkg::*;

  localparam int LAST = (WR_DLY > RD_DLY) ? WR_DLY : RD_DLY;
  localparam int AW   = ctr_bits(LAST + 1);
  localparam logic [AW-1:0] IDLE  = AW'(LAST + 1);
  localparam logic [AW-1:0] WR_AT = AW'(WR_DLY);
  localparam logic [AW-1:0] RD_AT = AW'(RD_DLY);

  logic          fs_q;
  logic [AW-1:0] age;

  assign fs_rise = enable && fsync && !fs_q;
  assign wr_tick = enable && (age == WR_AT);
  assign rd_tick = enable && (age == RD_AT);

  // age counts clock edges since frame edge 0, then parks at IDLE
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b1;
      age  <= IDLE;
    end else begin
      fs_q <= fsync;
      if (fs_rise)           age <= AW'(1);
      else if (age != IDLE)  age <= age + AW'(1);
    end
  end

endmodule

// File: rtl/pio_out_latch.sv
`timescale 1ns/1ps
module pio_out_latch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_mode,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  input  logic         upd_tick,
  output logic [W-1:0] lat
);

  logic [W-1:0] pend;
  logic         pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '1;
      pend_vld <= 1'b0;
    end else if (!data_mode) begin
      pend_vld <= 1'b0;                 // leaving data mode drops it
    end else if (wr_fire) begin
      pend     <= wr_data;              // newest write overwrites
      pend_vld <= 1'b1;
    end else if (upd_tick) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lat <= '1;
    else if (upd_tick && pend_vld) lat <= pend;
  end

endmodule

// File: rtl/pio_readback.sv
`timescale 1ns/1ps
module pio_readback #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_lvl,
  input  logic         ctl_stb,
  input  logic         rd_tick,
  input  logic         fs_rise,
  output logic [W-1:0] ctl_status,
  output logic [W-1:0] data_rd
);

  logic [W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_status <= '1;
      hold       <= '1;
      data_rd    <= '1;
    end else begin
      if (ctl_stb) ctl_status <= pin_lvl;
      if (rd_tick) hold       <= pin_lvl;
      if (fs_rise) data_rd    <= hold;
    end
  end

endmodule

// File: rtl/pio_port.sv
`timescale 1ns/1ps
module pio_port #(
  parameter int N_PIN       = 2,
  parameter int WR_DLY      = 11,
  parameter int RD_DLY      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_data,
  input  logic             fsync,
  input  logic             ctl_smp_stb,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [N_PIN-1:0] wr_data,
  input  logic [N_PIN-1:0] pin_in,
  output logic [N_PIN-1:0] pin_oe,
  output logic [N_PIN-1:0] ctl_status,
  output logic [N_PIN-1:0] data_rd
);
  import pio_pkg::*;

  pio_mode_e        mode;
  logic             in_data;
  logic             wr_fire;
  logic             ctl_stb;
  logic             fs_rise;
  logic             wr_tick;
  logic             rd_tick;
  logic [N_PIN-1:0] pin_lvl;
  logic [N_PIN-1:0] lat;

  assign mode     = pio_mode_e'(mode_data);
  assign in_data  = (mode == MODE_DATA);
  assign wr_ready = in_data;
  assign wr_fire  = wr_valid && wr_ready;
  assign ctl_stb  = ctl_smp_stb && (mode == MODE_CTL);
  assign pin_oe   = ~lat;

  pio_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
  );

  pio_frame_timer #(.WR_DLY(WR_DLY), .RD_DLY(RD_DLY)) i_timer (
    .clk(clk), .rst_n(rst_n), .enable(in_data), .fsync(fsync),
    .fs_rise(fs_rise), .wr_tick(wr_tick), .rd_tick(rd_tick)
  );

  pio_out_latch #(.W(N_PIN)) i_latch (
    .clk(clk), .rst_n(rst_n), .data_mode(in_data), .wr_fire(wr_fire),
    .wr_data(wr_data), .upd_tick(wr_tick), .lat(lat)
  );

  pio_readback #(.W(N_PIN)) i_rdbk (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .ctl_stb(ctl_stb),
    .rd_tick(rd_tick), .fs_rise(fs_rise),
    .ctl_status(ctl_status), .data_rd(data_rd)
  );

endmodule

// File: rtl/pio_port_chk.sv
`timescale 1ns/1ps
module pio_port_chk #(
  parameter int N_PIN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_data,
  input logic             ctl_smp_stb,
  input logic [N_PIN-1:0] pin_oe,
  input logic [N_PIN-1:0] ctl_status,
  input logic [N_PIN-1:0] data_rd,
  input logic             fs_rise,
  input logic             wr_tick
);

  p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == '0));

  p_ctl_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_data |=> $stable(pin_oe));

  p_ctl_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_status) |-> $past(ctl_smp_stb && !mode_data));

  p_oe_at_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_tick));

  p_rd_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_rd) |-> $past(fs_rise));

endmodule

bind pio_port pio_port_chk #(.N_PIN(N_PIN)) i_pio_chk (
  .clk(clk), .rst_n(rst_n), .mode_data(mode_data), .ctl_smp_stb(ctl_smp_stb),
  .pin_oe(pin_oe), .ctl_status(ctl_status), .data_rd(data_rd),
  .fs_rise(fs_rise), .wr_tick(wr_tick)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
  localparam int N      = 2;
  localparam int WR_DLY = 11;
  localparam int FRAME  = 32;

  // {wr_data, external level, expected pin_oe, expected sampled level}
  localparam logic [7:0] VEC [6] = '{
    8'b10_11_01_11,
    8'b01_11_10_10,
    8'b11_01_00_01,
    8'b00_11_11_11,
    8'b11_10_00_00,
    8'b11_11_00_11
  };

  logic clk = 1'b0, rst_n = 1'b0, mode_data = 1'b1, fsync = 1'b0;
  logic ctl_smp_stb = 1'b0, wr_valid = 1'b0, wr_ready;
  logic [N-1:0] wr_data = '1, ext = '1, pad, pin_oe, ctl_status, data_rd;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pad = ext & ~pin_oe;   // wired-AND of pull-up/external and pull-down

  pio_port #(.N_PIN(N), .WR_DLY(WR_DLY), .RD_DLY(8)) i_pio_port (
    .clk(clk), .rst_n(rst_n), .mode_data(mode_data), .fsync(fsync),
    .ctl_smp_stb(ctl_smp_stb), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pin_in(pad), .pin_oe(pin_oe),
    .ctl_status(ctl_status), .data_rd(data_rd)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [N-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // leaves the bench just after frame edge 0
  task automatic start_frame();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk);
  endtask

  // from after edge 0: drop fsync, check pin_oe either side of edge WR_DLY
  task automatic finish_frame(input string tag, input logic [N-1:0] oe_old,
                              input logic [N-1:0] oe_new);
    repeat (3) @(negedge clk);
    fsync = 1'b0;
    repeat (WR_DLY - 4) @(negedge clk);
    chk({tag, " before update"}, pin_oe, oe_old);
    @(negedge clk);
    chk({tag, " at update"}, pin_oe, oe_new);
    repeat (FRAME - WR_DLY - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pin_oe", pin_oe, 2'b00);
    chk("R1 ctl_status", ctl_status, 2'b11);
    chk("R1 data_rd", data_rd, 2'b11);
    chk("R1 wr_ready", {1'b0, wr_ready}, 2'b01);

    // vector walk (R2 R5 R7)
    for (int i = 0; i < 6; i++) begin
      ext = VEC[i][5:4];
      do_write(VEC[i][7:6]);
      start_frame();
      if (i == 0) chk("R1 first frame data_rd", data_rd, 2'b11);
      else        chk("R7 data_rd", data_rd, VEC[i-1][1:0]);
      finish_frame("R2 R5", (i == 0) ? 2'b00 : VEC[i-1][3:2], VEC[i][3:2]);
    end

    // R10: no write, latch holds; R7 for last vector
    start_frame();
    chk("R7 data_rd last vector", data_rd, VEC[5][1:0]);
    finish_frame("R10", 2'b00, 2'b00);

    // R6: last of two writes wins
    do_write(2'b01);
    do_write(2'b10);
    start_frame();
    chk("R7 data_rd idle frame", data_rd, 2'b11);
    finish_frame("R6", 2'b00, 2'b01);

    // release both pads again
    do_write(2'b11);
    start_frame();
    finish_frame("R2 release", 2'b01, 2'b00);

    // R9 + R3: pending write, then control mode
    do_write(2'b00);
    @(negedge clk); mode_data = 1'b0;
    @(negedge clk);
    chk("R3 wr_ready low", {1'b0, wr_ready}, 2'b00);
    wr_valid = 1'b1; wr_data = 2'b00;
    repeat (2) @(negedge clk);
    wr_valid = 1'b0;
    start_frame();
    chk("R3 data_rd frozen", data_rd, 2'b11);
    finish_frame("R3", 2'b00, 2'b00);

    // R4 control-mode capture
    ext = 2'b01;
    repeat (3) @(negedge clk);
    ctl_smp_stb = 1'b1; @(negedge clk); ctl_smp_stb = 1'b0;
    chk("R4 capture", ctl_status, 2'b01);
    ext = 2'b10;
    repeat (3) @(negedge clk);
    chk("R4 hold without strobe", ctl_status, 2'b01);
    ctl_smp_stb = 1'b1; @(negedge clk); ctl_smp_stb = 1'b0;
    chk("R4 second capture", ctl_status, 2'b10);
    ext = 2'b11; ctl_smp_stb = 1'b1;
    @(negedge clk); ctl_smp_stb = 1'b0;
    chk("R4 synchronizer latency", ctl_status, 2'b10);
    repeat (2) @(negedge clk);
    ctl_smp_stb = 1'b1; @(negedge clk); ctl_smp_stb = 1'b0;
    chk("R4 after latency", ctl_status, 2'b11);

    // R9: back to data mode, discarded write must not apply
    mode_data = 1'b1;
    start_frame();
    chk("R7 data_rd resumes", data_rd, 2'b10);
    finish_frame("R9", 2'b00, 2'b00);

    // R8: strobe ignored in data mode
    ext = 2'b00;
    repeat (3) @(negedge clk);
    ctl_smp_stb = 1'b1; @(negedge clk); ctl_smp_stb = 1'b0;
    chk("R8 strobe ignored", ctl_status, 2'b11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule